// File: doc/BRIEF.md
# Punctured Convolutional Encoder

This block turns a serial stream of information bits into a stream of coded bits. Each bit accepted enters a rate-1/2 convolutional code with constraint length 7, which gives 64 states. The code forms two parity bits, X and Y, from the new bit and the six bits before it. A puncturing stage then drops some of those coded bits, following a keep pattern that repeats with a fixed period. The rate select picks one of five code rates: 1/2, 2/3, 3/4, 5/6 or 7/8. The bits that are kept leave one per cycle on a serial output that has a valid strobe. A receiver later puts erasures back into the dropped positions and decodes the stream as rate 1/2.

At rate 1/2 the encoder sends two output bits for every input bit. For this reason the input side has a ready signal, and it holds off new bits while the two-bit output buffer drains. A block-start pulse clears the code register and the puncture phase, so that each block is encoded from the all-zero state.

Top module: `punct_conv_encoder`

## Requirements
- R1: After reset, `out_valid_o` is low and `in_ready_o` is high, and both the code register and the puncture phase are zero.
- R2: For each accepted bit b, X is the XOR of the taps of octal 171 and Y is the XOR of the taps of octal 133. The taps are applied over the 7-bit window {b, s5..s0}, where s5 is the previous bit and b is the most significant tap. After that, b shifts into the register.
- R3: The `rate_i` codes are 0=1/2, 1=2/3, 2=3/4, 3=5/6 and 4=7/8. The keep patterns are listed by period position from first to last (1 = sent). For 2/3: X 10, Y 11. For 3/4: X 101, Y 110. For 5/6: X 10101, Y 11010. For 7/8: X 1000101, Y 1111010. At rate 1/2 both X and Y are always kept.
- R4: The kept bits of one input bit appear in the order X then Y. They appear on consecutive cycles, starting in the cycle after the input is accepted.
- R5: A cycle with `blk_start_i` high clears the code register and the puncture phase. It also holds `in_ready_o` low. Bits already in the output buffer still drain.
- R6: The rate is sampled only when the first bit of a period is accepted. A change to `rate_i` during the rest of the period has no effect until the next period starts.
- R7: `in_ready_o` is low whenever two kept bits are waiting in the output buffer. No input is accepted then.
- R8: `out_valid_o` is high only while kept bits remain. It falls once the buffer is empty and no new input arrives.
- R9: The `rate_i` codes 5, 6 and 7 behave as rate 1/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_start_i | input | 1 | Clears the code register and the puncture phase |
| rate_i | input | 3 | Code rate select (see R3) |
| in_valid_i | input | 1 | An input bit is offered |
| in_bit_i | input | 1 | Input information bit |
| in_ready_o | output | 1 | The encoder can take the offered bit |
| out_valid_o | output | 1 | `out_bit_o` holds a kept coded bit |
| out_bit_o | output | 1 | Serial coded output bit |

## Verification
A bit accepted on a rising edge puts its first kept bit on the output in the next cycle. A second kept bit, if there is one, follows one cycle after that. The output buffer is registered, so `in_ready_o` is low in the cycle after a two-bit load and high again the cycle after that. The driver pushes each expected kept bit into a queue at the moment of acceptance. The monitor samples on falling edges and compares one queue entry whenever `out_valid_o` is high, which checks order and latency without fixed delays. The ready, idle and block-start checks are sampled on the falling edge that follows the edge that caused them.

// File: rtl/pce_pkg.sv
package pce_pkg;

    localparam int RATE_W     = 3;
    localparam int MAX_PERIOD = 7;
    localparam int PHASE_W    = $clog2(MAX_PERIOD + 1);

    typedef enum logic [RATE_W-1:0] {
        RATE_1_2 = 3'd0,
        RATE_2_3 = 3'd1,
        RATE_3_4 = 3'd2,
        RATE_5_6 = 3'd3,
        RATE_7_8 = 3'd4
    } rate_e;

    // Keep masks: bit p set means the bit at period position p is sent.
    function automatic logic [PHASE_W-1:0] period_len(input logic [RATE_W-1:0] r);
        case (r)
            RATE_2_3: return PHASE_W'(2);
            RATE_3_4: return PHASE_W'(3);
            RATE_5_6: return PHASE_W'(5);
            RATE_7_8: return PHASE_W'(7);
            default:  return PHASE_W'(1);
        endcase
    endfunction

    function automatic logic [MAX_PERIOD-1:0] keep_x_mask(input logic [RATE_W-1:0] r);
        case (r)
            RATE_2_3: return 7'b0000001;
            RATE_3_4: return 7'b0000101;
            RATE_5_6: return 7'b0010101;
            RATE_7_8: return 7'b1010001;
            default:  return 7'b0000001;
        endcase
    endfunction

    function automatic logic [MAX_PERIOD-1:0] keep_y_mask(input logic [RATE_W-1:0] r);
        case (r)
            RATE_2_3: return 7'b0000011;
            RATE_3_4: return 7'b0000011;
            RATE_5_6: return 7'b0001011;
            RATE_7_8: return 7'b0101111;
            default:  return 7'b0000001;
        endcase
    endfunction

endpackage

// File: rtl/pce_conv_core.sv
module pce_conv_core #(
    parameter int          K    = 7,
    parameter logic [K-1:0] G_X = 7'o171,
    parameter logic [K-1:0] G_Y = 7'o133
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic adv_i,
    input  logic bit_i,
    output logic x_o,
    output logic y_o
);
    localparam int SR_W = K - 1;

    typedef struct packed {
        logic [SR_W-1:0] sr;
    } core_t;

    core_t cur_q, nxt_d;
    logic [K-1:0] window;

    always_comb begin
        window = {bit_i, cur_q.sr};
        x_o    = ^(window & G_X);
        y_o    = ^(window & G_Y);
        nxt_d  = cur_q;
        if (clr_i) begin
            nxt_d.sr = '0;
        end else if (adv_i) begin
            nxt_d.sr = {bit_i, cur_q.sr[SR_W-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cur_q.sr == '0)); // R5
    AST_BIT_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && !clr_i) |=> (cur_q.sr[SR_W-1] == $past(bit_i))); // R2

endmodule

// File: rtl/pce_puncture.sv
module pce_puncture
    import pce_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              adv_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              keep_x_o,
    output logic              keep_y_o
);
    typedef struct packed {
        logic [PHASE_W-1:0] phase;
        logic [RATE_W-1:0]  rate;
    } punc_t;

    punc_t cur_q, nxt_d;
    logic [RATE_W-1:0]  eff_rate;
    logic [PHASE_W-1:0] last_pos;

    always_comb begin
        eff_rate = (cur_q.phase == '0) ? rate_i : cur_q.rate;
        last_pos = period_len(eff_rate) - PHASE_W'(1);
        keep_x_o = keep_x_mask(eff_rate)[cur_q.phase];
        keep_y_o = keep_y_mask(eff_rate)[cur_q.phase];
        nxt_d    = cur_q;
        if (clr_i) begin
            nxt_d.phase = '0;
        end else if (adv_i) begin
            if (cur_q.phase == '0) nxt_d.rate = rate_i;
            nxt_d.phase = (cur_q.phase == last_pos) ? '0 : cur_q.phase + PHASE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    AST_PHASE_IN_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.phase != '0) |-> (cur_q.phase < period_len(cur_q.rate))); // R3
    AST_RATE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(adv_i && cur_q.phase == '0) |=> $stable(cur_q.rate)); // R6
    AST_PHASE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (cur_q.phase == '0)); // R5
    AST_SOME_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i |-> (keep_x_o || keep_y_o)); // R3

endmodule

// File: rtl/pce_serializer.sv
module pce_serializer #(
    parameter int SLOTS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    input  logic x_i,
    input  logic y_i,
    input  logic keep_x_i,
    input  logic keep_y_i,
    output logic room_o,
    output logic out_valid_o,
    output logic out_bit_o
);
    localparam int CNT_W = $clog2(SLOTS + 1);

    typedef struct packed {
        logic [SLOTS-1:0] buf_;
        logic [CNT_W-1:0] cnt;
    } ser_t;

    ser_t cur_q, nxt_d;

    always_comb begin
        room_o      = (cur_q.cnt <= CNT_W'(1));
        out_valid_o = (cur_q.cnt != '0);
        out_bit_o   = cur_q.buf_[0];
        nxt_d       = cur_q;
        if (load_i) begin
            nxt_d.cnt  = CNT_W'(keep_x_i) + CNT_W'(keep_y_i);
            nxt_d.buf_ = keep_x_i ? {y_i, x_i} : {1'b0, y_i};
        end else if (cur_q.cnt != '0) begin
            nxt_d.cnt  = cur_q.cnt - CNT_W'(1);
            nxt_d.buf_ = {1'b0, cur_q.buf_[SLOTS-1:1]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    AST_LOAD_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |-> (cur_q.cnt <= CNT_W'(1))); // R7
    AST_LOAD_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> out_valid_o); // R4
    AST_IDLE_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && cur_q.cnt <= CNT_W'(1)) |=> !out_valid_o); // R8

endmodule

// File: rtl/punct_conv_encoder.sv
module punct_conv_encoder
    import pce_pkg::*;
#(
    parameter int K = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              blk_start_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              in_valid_i,
    input  logic              in_bit_i,
    output logic              in_ready_o,
    output logic              out_valid_o,
    output logic              out_bit_o
);
    logic room, accept, x_bit, y_bit, keep_x, keep_y;

    always_comb begin
        in_ready_o = room && !blk_start_i;
        accept     = in_valid_i && in_ready_o;
    end

    pce_conv_core #(.K(K)) u_core (
        .clk(clk), .rst_n(rst_n), .clr_i(blk_start_i), .adv_i(accept),
        .bit_i(in_bit_i), .x_o(x_bit), .y_o(y_bit)
    );

    pce_puncture u_punc (
        .clk(clk), .rst_n(rst_n), .clr_i(blk_start_i), .adv_i(accept),
        .rate_i(rate_i), .keep_x_o(keep_x), .keep_y_o(keep_y)
    );

    pce_serializer #(.SLOTS(2)) u_ser (
        .clk(clk), .rst_n(rst_n), .load_i(accept), .x_i(x_bit), .y_i(y_bit),
        .keep_x_i(keep_x), .keep_y_i(keep_y), .room_o(room),
        .out_valid_o(out_valid_o), .out_bit_o(out_bit_o)
    );

    AST_NO_ACCEPT_IN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        blk_start_i |-> !in_ready_o); // R5
    AST_ACCEPT_THEN_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o) |=> out_valid_o); // R4

endmodule

// File: tb/tb_punct_conv_encoder.sv
module tb_punct_conv_encoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic blk_start = 1'b0;
    logic [2:0] rate = 3'd0;
    logic in_valid = 1'b0;
    logic in_bit = 1'b0;
    logic in_ready, out_valid, out_bit;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    string cur_tag = "R1";

    bit    exp_q[$];
    string tag_q[$];

    logic [5:0] m_sr = '0;
    int         m_phase = 0;
    logic [2:0] m_rate = '0;
    logic [15:0] lfsr = 16'hACE1;

    always #5 clk = ~clk;

    punct_conv_encoder dut (
        .clk(clk), .rst_n(rst_n), .blk_start_i(blk_start), .rate_i(rate),
        .in_valid_i(in_valid), .in_bit_i(in_bit), .in_ready_o(in_ready),
        .out_valid_o(out_valid), .out_bit_o(out_bit)
    );

    task automatic check(input string req, input logic act, input logic exp_v);
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp_v, $time);
        end
    endtask

    // Spec tables, written from the keep strings, first position = p 0.
    function automatic int plen(input logic [2:0] r);
        case (r) 3'd1: return 2; 3'd2: return 3; 3'd3: return 5; 3'd4: return 7;
            default: return 1; endcase
    endfunction

    function automatic bit kx(input logic [2:0] r, input int p);
        string s;
        case (r) 3'd1: s = "10"; 3'd2: s = "101"; 3'd3: s = "10101";
            3'd4: s = "1000101"; default: s = "1"; endcase
        return s[p] == "1";
    endfunction

    function automatic bit ky(input logic [2:0] r, input int p);
        string s;
        case (r) 3'd1: s = "11"; 3'd2: s = "110"; 3'd3: s = "11010";
            3'd4: s = "1111010"; default: s = "1"; endcase
        return s[p] == "1";
    endfunction

    task automatic send(input logic b, input logic [2:0] r);
        logic [6:0] w;
        int nk;
        @(negedge clk);
        rate = r; in_bit = b; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        if (m_phase == 0) m_rate = r;
        w = {b, m_sr};
        nk = 0;
        if (kx(m_rate, m_phase)) begin exp_q.push_back(^(w & 7'o171)); tag_q.push_back(cur_tag); nk++; end
        if (ky(m_rate, m_phase)) begin exp_q.push_back(^(w & 7'o133)); tag_q.push_back(cur_tag); nk++; end
        m_sr = {b, m_sr[5:1]};
        m_phase = (m_phase + 1) % plen(m_rate);
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        if (nk == 2) check("R7 ready low with two pending", in_ready, 1'b0);
    endtask

    task automatic block_start();
        @(negedge clk);
        blk_start = 1'b1;
        #1 check("R5 ready low during block start", in_ready, 1'b0);
        @(negedge clk);
        blk_start = 1'b0;
        m_sr = '0; m_phase = 0;
    endtask

    function automatic logic next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return lfsr[0];
    endfunction

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid && !done) begin
            if (exp_q.size() == 0) begin
                check("R8 unexpected output", out_valid, 1'b0);
            end else begin
                automatic bit e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, out_bit, e);
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 out_valid after reset", out_valid, 1'b0);
        check("R1 in_ready after reset", in_ready, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid idle", out_valid, 1'b0);

        // Impulse response at rate 1/2
        cur_tag = "R2 R4 impulse rate 1/2";
        send(1'b1, 3'd0);
        for (int i = 0; i < 7; i++) send(1'b0, 3'd0);
        drain();

        // Each punctured rate with pseudo-random data
        for (int r = 1; r <= 4; r++) begin
            block_start();
            cur_tag = $sformatf("R3 rate code %0d", r);
            for (int i = 0; i < 28; i++) send(next_rand(), 3'(r));
            drain();
        end

        // Block start in the middle of a period
        cur_tag = "R5 restart mid-period";
        block_start();
        send(1'b1, 3'd4); send(1'b1, 3'd4); send(1'b0, 3'd4);
        block_start();
        for (int i = 0; i < 14; i++) send(next_rand(), 3'd4);
        drain();

        // Rate change inside a period is ignored
        cur_tag = "R6 mid-period rate change";
        block_start();
        send(1'b1, 3'd2); send(1'b0, 3'd1); send(1'b1, 3'd0);
        send(1'b1, 3'd1); send(1'b1, 3'd3); send(1'b0, 3'd3);
        for (int i = 0; i < 10; i++) send(next_rand(), 3'd3);
        drain();

        // Unsupported codes act as rate 1/2
        cur_tag = "R9 unsupported code";
        block_start();
        for (int i = 0; i < 9; i++) send(next_rand(), 3'(5 + (i % 3)));
        drain();

        @(negedge clk);
        check("R8 out_valid low when drained", out_valid, 1'b0);
        checks++;
        if (exp_q.size() != 0) begin
            fails++;
            $display("FAIL R4: got %0d bits missing expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule